// File: doc/BRIEF.md
# Secondary Bus Two-Level Rotating Arbiter

This block decides which master on a secondary PCI bus may drive the bus next. It serves up to `NUM_EXT` external masters plus the bridge itself, which sits at request index `NUM_EXT`. A mask places each requester in a high or a low priority group. Masters in the high group take turns in ascending index order. The low group as a whole owns one extra slot in that rotation, and it keeps its own turn order among its members.

The block watches the bus FRAME and IRDY lines. A grant that moves while the bus is idle is withdrawn for one clock before the next master sees its grant. While a transaction is in progress, the grant moves in a single clock. With nobody asking, the grant stays parked on the last owner, and out of reset it is parked on the bridge. A configurable preemption timer takes the grant from a master that still asserts its request but does not begin a transaction while another master is waiting.

Top module: `sec_bus_arbiter`

## Requirements
- R1: At no time is more than one bit of `gnt_n` low.
- R2: While reset is applied and in the first cycle after it, only `gnt_n[NUM_EXT]` (the bridge) is low. Both rotation pointers restart at index 0.
- R3: When no `req_n` bit is low, the current grant does not change.
- R4: If the grant moves at a clock edge where the bus is idle (`frame_n` and `irdy_n` both high), that edge drives all `gnt_n` bits high. The next edge asserts the new grant, so the gap lasts exactly one cycle.
- R5: If the grant moves at a clock edge where `frame_n` or `irdy_n` is low, the old grant drops and the new one rises at that same edge, with no all-high cycle.
- R6: The top-level order visits the high-group members (`hi_grp` bit = 1) in ascending index, followed by one slot for the low group (`hi_grp` bit = 0). The search starts just past the last slot granted. After a low-group grant it resumes at index 0.
- R7: Inside the low group, members are searched in ascending index starting just past the last low member granted. The current holder is never chosen again while any other request is pending.
- R8: With another request pending, the holder gives up its grant when any of the following is true: its own `req_n` is high; it has started a transaction (the bus went from idle to busy while it held the grant); or the preemption timer expired. Otherwise it keeps the grant, even while the bus is busy.
- R9: The timer counts the edges at which all of these hold: another request is pending, the bus is idle, and the holder is requesting but has not started. The grant is withdrawn on count L, where `tpre_sel` 000 gives L=32, 001 gives 8, 010 gives 16 and 011 gives 64. Any code 1xx disables preemption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_EXT+1 | Active-low requests; bit NUM_EXT is the bridge |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| hi_grp | input | NUM_EXT+1 | Group mask: 1 = high group, 0 = low group |
| tpre_sel | input | 3 | Preemption time code |
| gnt_n | output | NUM_EXT+1 | Active-low grants |

## Verification
All grant outputs are decoded from registers, so a decision made from the inputs seen at edge k appears at edge k. An idle handoff shows all-high after edge k and the new owner after edge k+1. A busy handoff shows the new owner directly after edge k, and a preemption drop appears after the L-th counting edge. The bench drives inputs at the falling edge and samples two time units after each rising edge. It therefore counts rising edges from each stimulus and compares the outputs at exactly those edges. The rotation order for several group masks is produced by an arithmetic model of the two rings in the bench.

// File: rtl/sba_pkg.sv
package sba_pkg;

    // Grant phase: a grant is either held, or withdrawn for one cycle on an idle handoff
    typedef enum logic {
        PH_HELD = 1'b0,
        PH_GAP  = 1'b1
    } grant_phase_e;

    // Low two bits of the preemption code; bit 2 set disables preemption
    typedef enum logic [2:0] {
        TP_32 = 3'b000,
        TP_8  = 3'b001,
        TP_16 = 3'b010,
        TP_64 = 3'b011
    } preempt_code_e;

    // Decision for one cycle
    typedef struct packed {
        logic release_now;   // grant leaves the holder this edge
        logic busy_path;     // bus busy: direct swap, no gap
        logic to_low;        // winner came from the low-group slot
    } sba_move_t;

    // Clocks before preemption; 0 means never
    function automatic int preempt_clocks(input logic [2:0] code);
        if (code[2]) return 0;
        case (preempt_code_e'({1'b0, code[1:0]}))
            TP_32:   return 32;
            TP_8:    return 8;
            TP_16:   return 16;
            default: return 64;
        endcase
    endfunction

    // Position one step further round a ring of the given size
    function automatic int ring_next(input int pos, input int size);
        return (pos + 1 >= size) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/sba_ring_pick.sv
module sba_ring_pick #(
    parameter int WIDTH = 10,
    localparam int PW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cand,
    input  logic [PW-1:0]    start,
    output logic             hit,
    output logic [PW-1:0]    pos
);

    // First candidate at or after start, wrapping round the ring
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (!hit && cand[(int'(start) + k) % WIDTH]) begin
                hit = 1'b1;
                pos = PW'((int'(start) + k) % WIDTH);
            end
        end
    end

endmodule

// File: rtl/sba_preempt_timer.sv
module sba_preempt_timer
    import sba_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       expire
);

    logic [CW-1:0] cnt_q;
    int            limit;

    always_comb begin
        limit  = preempt_clocks(code);
        expire = run && (limit != 0) && (int'(cnt_q) + 1 == limit);
    end

    // Counts consecutive qualifying edges; any break restarts the window
    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
    import sba_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int TMR_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT:0]   req_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic [NUM_EXT:0]   hi_grp,
    input  logic [2:0]         tpre_sel,
    output logic [NUM_EXT:0]   gnt_n
);

    localparam int N       = NUM_EXT + 1;
    localparam int SLOTS   = N + 1;
    localparam int IW      = $clog2(N);
    localparam int SW      = $clog2(SLOTS);
    localparam int BRG     = NUM_EXT;
    localparam int LOWSLOT = N;

    // Registered state
    grant_phase_e  phase_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] pend_q;
    logic [IW-1:0] lptr_q;
    logic [SW-1:0] hptr_q;
    logic          started_q;
    logic          busy_q;

    // Request views
    logic [N-1:0]     req, own_oh, cand, hi_cand, lo_cand;
    logic [SLOTS-1:0] slot_cand;
    logic             owner_req, bus_busy, start_seen, used;

    assign req      = ~req_n;
    assign bus_busy = ~frame_n | ~irdy_n;

    for (genvar i = 0; i < N; i++) begin : g_own
        assign own_oh[i] = (owner_q == IW'(i));
    end

    // The holder is taken out of the search, so a move always goes elsewhere
    assign cand      = req & ~own_oh;
    assign hi_cand   = cand & hi_grp;
    assign lo_cand   = cand & ~hi_grp;
    assign slot_cand = {|lo_cand, hi_cand};
    assign owner_req = |(req & own_oh);

    // Two-level search
    logic          top_hit, low_hit;
    logic [SW-1:0] top_pos;
    logic [IW-1:0] low_pos;

    sba_ring_pick #(.WIDTH(SLOTS)) u_top (
        .cand  (slot_cand),
        .start (hptr_q),
        .hit   (top_hit),
        .pos   (top_pos)
    );

    sba_ring_pick #(.WIDTH(N)) u_low (
        .cand  (lo_cand),
        .start (lptr_q),
        .hit   (low_hit),
        .pos   (low_pos)
    );

    logic          win_low, win_valid;
    logic [IW-1:0] win_idx;
    logic [SW-1:0] hptr_nx;
    logic [IW-1:0] lptr_nx;

    always_comb begin
        win_low   = (top_pos == SW'(LOWSLOT));
        win_valid = top_hit && (!win_low || low_hit);
        win_idx   = win_low ? low_pos : top_pos[IW-1:0];
        hptr_nx   = win_low ? '0 : SW'(ring_next(int'(top_pos), SLOTS));
        lptr_nx   = IW'(ring_next(int'(low_pos), N));
    end

    // Holder activity: a start is the bus leaving idle while the grant is held
    assign start_seen = bus_busy && !busy_q;
    assign used       = started_q || start_seen;

    // Preemption of a holder that requests but never starts
    logic tmr_run, tmr_expire;

    assign tmr_run = (phase_q == PH_HELD) && !used && !bus_busy && owner_req && win_valid;

    sba_preempt_timer #(.CW(TMR_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (tmr_run),
        .code   (tpre_sel),
        .expire (tmr_expire)
    );

    sba_move_t mv;

    always_comb begin
        mv.release_now = (phase_q == PH_HELD) && win_valid && (!owner_req || used || tmr_expire);
        mv.busy_path   = bus_busy;
        mv.to_low      = win_low;
    end

    // Grant sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_HELD;
            owner_q   <= IW'(BRG);
            pend_q    <= IW'(BRG);
            hptr_q    <= '0;
            lptr_q    <= '0;
            started_q <= 1'b0;
            busy_q    <= 1'b0;
        end else begin
            busy_q <= bus_busy;
            case (phase_q)
                PH_HELD: begin
                    if (mv.release_now) begin
                        hptr_q    <= hptr_nx;
                        if (mv.to_low) lptr_q <= lptr_nx;
                        started_q <= 1'b0;
                        if (mv.busy_path) begin
                            owner_q <= win_idx;
                        end else begin
                            phase_q <= PH_GAP;
                            pend_q  <= win_idx;
                        end
                    end else if (start_seen) begin
                        started_q <= 1'b1;
                    end
                end
                PH_GAP: begin
                    phase_q   <= PH_HELD;
                    owner_q   <= pend_q;
                    started_q <= 1'b0;
                end
                default: phase_q <= PH_HELD;
            endcase
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_gnt
        assign gnt_n[i] = ~((phase_q == PH_HELD) && (owner_q == IW'(i)));
    end

endmodule

// File: rtl/sba_chk.sv
module sba_chk #(
    parameter int NUM_EXT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NUM_EXT:0] req_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [NUM_EXT:0] gnt_n
);

    localparam int N = NUM_EXT + 1;
    localparam logic [N-1:0] PARK = ~(N'(1) << NUM_EXT);

    logic gnt_any, busy;
    assign gnt_any = ~&gnt_n;
    assign busy    = ~frame_n | ~irdy_n;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));                                              // R1

    AST_RESET_PARK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gnt_n == PARK));                                // R2

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (&req_n && gnt_any) |=> $stable(gnt_n));                        // R3

    AST_GAP_ONE: assert property (@(posedge clk) disable iff (rst)
        !gnt_any |=> gnt_any);                                          // R4

    AST_IDLE_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
        (gnt_any && !busy) |=> (!gnt_any || $stable(gnt_n)));           // R4

    AST_BUSY_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (gnt_any && busy) |=> gnt_any);                                 // R5

endmodule

bind sec_bus_arbiter sba_chk #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
);

// File: tb/sim_sec_bus_arbiter.sv
module sim_sec_bus_arbiter;

    localparam int CLK_P = 10;
    localparam int NE    = 8;
    localparam int N     = NE + 1;
    localparam int BRG   = NE;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic [N-1:0] hi_grp = '0;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic [2:0]   tpre_sel = 3'b000;
    logic [N-1:0] gnt_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    sec_bus_arbiter #(.NUM_EXT(NE)) u0 (
        .clk      (clk),
        .rst      (rst),
        .req_n    (req_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .hi_grp   (hi_grp),
        .tpre_sel (tpre_sel),
        .gnt_n    (gnt_n)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Index of the single low grant; -1 none, -2 several
    function automatic int gidx(input logic [N-1:0] g);
        int c = 0;
        int p = -1;
        for (int i = 0; i < N; i++) if (!g[i]) begin c++; p = i; end
        if (c == 0) return -1;
        if (c > 1)  return -2;
        return p;
    endfunction

    // Arithmetic model of the two rings: high members then a low slot
    function automatic int pick(input logic [N-1:0] mask, input logic [N-1:0] rq,
                                input int own, inout int hp, inout int lp);
        logic [N-1:0] r, hi, lo;
        r = rq;
        r[own] = 1'b0;
        hi = r & mask;
        lo = r & ~mask;
        for (int k = 0; k < N + 1; k++) begin
            int s;
            s = (hp + k) % (N + 1);
            if (s < N && hi[s]) begin
                hp = (s + 1) % (N + 1);
                return s;
            end
            if (s == N && lo != '0) begin
                for (int m = 0; m < N; m++) begin
                    int t;
                    t = (lp + m) % N;
                    if (lo[t]) begin
                        lp = (t + 1) % N;
                        hp = 0;
                        return t;
                    end
                end
            end
        end
        return -1;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_n = '1;
        frame_n = 1'b1;
        irdy_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // R1 watched on every cycle
    always @(negedge clk) begin
        if (!rst) chk(gidx(gnt_n) != -2, "R1 one grant", gidx(gnt_n), 0);
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] masks [6];
        int lims [4];
        masks[0] = 9'h000; masks[1] = 9'h1FF; masks[2] = 9'h100;
        masks[3] = 9'h0A5; masks[4] = 9'h11B; masks[5] = 9'h0F0;
        lims[0] = 32; lims[1] = 8; lims[2] = 16; lims[3] = 64;

        // R2 reset park, R3 parking with no requests
        do_reset();
        chk(gidx(gnt_n) == BRG, "R2 reset park", gidx(gnt_n), BRG);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(gidx(gnt_n) == BRG, "R3 park idle", gidx(gnt_n), BRG);
        end

        // R4 idle handoff: gap then grant
        @(negedge clk); req_n[3] = 1'b0;
        tick(); chk(gidx(gnt_n) == -1, "R4 gap", gidx(gnt_n), -1);
        tick(); chk(gidx(gnt_n) == 3, "R4 new grant", gidx(gnt_n), 3);

        // R8 holder drops request: released at once
        @(negedge clk); req_n[3] = 1'b1; req_n[5] = 1'b0;
        tick(); chk(gidx(gnt_n) == -1, "R8 release on drop", gidx(gnt_n), -1);
        tick(); chk(gidx(gnt_n) == 5, "R8 next owner", gidx(gnt_n), 5);

        // R5 busy handoff in one edge
        @(negedge clk); frame_n = 1'b0; irdy_n = 1'b0; req_n[5] = 1'b1; req_n[1] = 1'b0;
        tick(); chk(gidx(gnt_n) == 1, "R5 busy swap", gidx(gnt_n), 1);
        @(negedge clk); frame_n = 1'b1; req_n[6] = 1'b0;
        tick(); chk(gidx(gnt_n) == 1, "R8 unstarted holder keeps", gidx(gnt_n), 1);
        @(negedge clk); irdy_n = 1'b1;
        tick(); chk(gidx(gnt_n) == 1, "R8 holder keeps idle", gidx(gnt_n), 1);
        @(negedge clk); frame_n = 1'b0; irdy_n = 1'b0;
        tick(); chk(gidx(gnt_n) == 6, "R5 swap after start", gidx(gnt_n), 6);
        @(negedge clk); frame_n = 1'b1; irdy_n = 1'b1; req_n = '1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(gidx(gnt_n) == 6, "R3 park on last", gidx(gnt_n), 6);
        end

        // R6 R7 rotation sweep over group masks, every master requesting
        for (int mi = 0; mi < 6; mi++) begin
            int own, hp, lp, exp;
            hi_grp = masks[mi];
            do_reset();
            chk(gidx(gnt_n) == BRG, "R2 reset park", gidx(gnt_n), BRG);
            req_n = '0;
            own = BRG; hp = 0; lp = 0;
            tick();
            for (int k = 0; k < 20; k++) begin
                exp = pick(masks[mi], '1, own, hp, lp);
                @(negedge clk); frame_n = 1'b0; irdy_n = 1'b0;
                tick(); chk(gidx(gnt_n) == exp, "R6 R7 order", gidx(gnt_n), exp);
                @(negedge clk); frame_n = 1'b1; irdy_n = 1'b1;
                tick(); chk(gidx(gnt_n) == exp, "R8 hold until start", gidx(gnt_n), exp);
                own = exp;
            end
        end
        hi_grp = '0;

        // R9 preemption windows
        for (int ci = 0; ci < 5; ci++) begin
            int e;
            bit dropped;
            do_reset();
            tpre_sel = (ci < 4) ? 3'(ci) : 3'b110;
            @(negedge clk); req_n[2] = 1'b0;
            tick(); tick();
            chk(gidx(gnt_n) == 2, "R9 setup grant", gidx(gnt_n), 2);
            @(negedge clk); req_n[6] = 1'b0;
            e = 0;
            dropped = 0;
            for (int t = 1; t <= 80 && !dropped; t++) begin
                tick();
                if (gidx(gnt_n) == -1) begin dropped = 1; e = t; end
            end
            if (ci < 4) begin
                chk(dropped && e == lims[ci], "R9 preempt edge", e, lims[ci]);
                tick(); chk(gidx(gnt_n) == 6, "R9 waiter granted", gidx(gnt_n), 6);
            end else begin
                chk(!dropped && gidx(gnt_n) == 2, "R9 preempt off", gidx(gnt_n), 2);
            end
        end

        done = 1;
        report();
        $finish;
    end

endmodule